// File: doc/BRIEF.md
# Two-Wire DAC Command Decoder

This block is the serial front end of a single-channel digital-to-analog converter. It is a two-wire (I2C) slave with 7-bit addressing. It runs on the system clock and takes oversampled SCL and SDA, which it passes through a synchroniser. It pulls SDA low through an open-drain enable. Once a write address has been acknowledged, the top three bits of the first data byte select a command. The command sets how many bytes make up the frame and which register set the frame updates: the volatile set, or both the volatile set and the nonvolatile set.

The volatile set drives the converter: the code, the reference select, the gain and the power-down mode. The nonvolatile set is a shadow copy. Whenever the copy changes, the block gives a one-cycle strobe so that a storage controller can program it. A read returns a packed status-and-configuration byte followed by the code bytes: first for the volatile set, then for the nonvolatile set. The master can keep writing frames back to back without sending a stop.

Top module: `dacif_top`

## Requirements
- R1: The slave acknowledges (holds SDA low during the ninth clock) only the address 7'b11000 followed by `addr_opt_i[1:0]`. The eighth bit is R/W (0 means write). The slave does not acknowledge any other address and then ignores the bus until the next start.
- R2: Command 00x is a 2-byte frame. The first byte is {0,0,PD1,PD0,D11..D8} and the second byte is D7..D0. The frame updates only the volatile code and the power-down bits.
- R3: Command 010 is a 3-byte frame. The bytes are {0,1,0,REF1,REF0,PD1,PD0,G}, then D11..D4, then {D3..D0,xxxx}. The frame updates the volatile code and all volatile configuration bits. The nonvolatile set is unchanged.
- R4: Command 011 has the same 3-byte layout as R3. It updates both the volatile set and the nonvolatile set, and raises `nv_wr_o` for exactly one clock cycle.
- R5: Command 100 is a 1-byte frame {1,0,0,REF1,REF0,PD1,PD0,G}. It updates only the volatile configuration bits. The code is kept.
- R6: Registers update at the SCL falling edge that ends the acknowledge of the frame's last byte. If a stop or a repeated start arrives earlier, the transfer changes nothing.
- R7: The slave does not acknowledge a first data byte whose command is 101, 110 or 111. No register changes.
- R8: Once a frame completes, the next byte of the same transfer starts a new frame with its own command.
- R9: A read returns six bytes and then wraps back to the first: {RDY,POR,0,REF1,REF0,PD1,PD0,G}, D11..D4, {D3..D0,0000} for the volatile set, then the same three bytes for the nonvolatile set. RDY is the inverse of `nv_busy_i`, and POR reads as 1.
- R10: After the master NACKs a read byte, the slave releases SDA until the next start condition.
- R11: After reset, every register is zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line (asynchronous) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_opt_i | input | 2 | Low two bits of the slave address |
| nv_busy_i | input | 1 | Nonvolatile store is programming |
| dac_code_o | output | CODE_W | Volatile converter code |
| ref_sel_o | output | 2 | Volatile reference select |
| gain_o | output | 1 | Volatile gain select |
| pd_o | output | 2 | Volatile power-down mode |
| nv_code_o | output | CODE_W | Nonvolatile code copy |
| nv_ref_sel_o | output | 2 | Nonvolatile reference select |
| nv_gain_o | output | 1 | Nonvolatile gain |
| nv_pd_o | output | 2 | Nonvolatile power-down mode |
| nv_wr_o | output | 1 | One-cycle strobe when the nonvolatile set changes |

## Verification
The hardest case to bring about is a frame cut short at a byte boundary. The truncated frame must leave every register untouched, even though the first bytes were acknowledged and stored. The bench sends the partial frame and then ends it either with a stop or with a repeated start that leads straight into a valid frame. After each case it compares every output with the model. A second hard case is a stream of mixed-length frames inside one transfer. The bench sends a 2-byte, a 1-byte and a 3-byte frame back to back, so that the frame-boundary tracking has to restart the command decode each time.

// File: rtl/dacif_pkg.sv
// Shared types for the DAC serial command decoder.
// Assumes frames carry a 12-bit code field, left-justified for narrower codes.
package dacif_pkg;
    typedef enum logic [2:0] {
        LS_IDLE, LS_ADDR, LS_AACK, LS_WBYTE, LS_WACK, LS_RBYTE, LS_RACK
    } link_st_e;

    typedef struct packed {
        logic [1:0] ref_sel;
        logic [1:0] pd;
        logic       gain;
    } dac_cfg_t;

    localparam int FRAME_CODE_W = 12;

    // Packs status and configuration into the byte layout seen by a reader.
    function automatic logic [7:0] pack_cfg(input logic rdy, input logic por, input dac_cfg_t c);
        return {rdy, por, 1'b0, c.ref_sel, c.pd, c.gain};
    endfunction
endpackage

// File: rtl/dacif_line_sync.sv
// Synchronises SCL/SDA into the clk domain and derives edge, start and stop events.
// Assumes both lines are sampled at least several times per SCL phase.
module dacif_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p, scl_s;

    // Shift both lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    // Event decode from current and previous synchronised values.
    always_comb begin
        scl_s    = scl_sh[STAGES-1];
        sda_s    = sda_sh[STAGES-1];
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/dacif_link.sv
// Bit and byte engine of the slave: address match, byte shifting, acknowledge
// driving and read serialisation. Assumes events come from dacif_line_sync.
module dacif_link
    import dacif_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [1:0] addr_opt,
    output logic       sda_oe,
    output logic       wbyte_valid,
    output logic [7:0] wbyte,
    input  logic       wbyte_ack,
    output logic       wack_done,
    output logic       rd_adv,
    input  logic [7:0] rd_byte
);
    link_st_e   st;
    logic [7:0] sh, tx;
    logic [3:0] cnt;
    logic       rw, mack;
    logic [6:0] my_addr;

    assign my_addr     = {ADDR_BASE[6:2], addr_opt};
    assign wbyte       = sh;
    assign wbyte_valid = (st == LS_WBYTE) && scl_fall && (cnt == 4'd8);
    assign wack_done   = (st == LS_WACK) && scl_fall;
    assign rd_adv      = (st == LS_RACK) && scl_rise && !sda_s;

    // Main slave sequencer, advanced by SCL edges and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LS_IDLE; sh <= '0; tx <= '0; cnt <= '0;
            rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
        end else if (start_ev) begin
            st <= LS_ADDR; cnt <= '0; sda_oe <= 1'b0;
        end else if (stop_ev) begin
            st <= LS_IDLE; sda_oe <= 1'b0;
        end else begin
            case (st)
                LS_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (sh[7:1] == my_addr) begin
                            st <= LS_AACK; sda_oe <= 1'b1; rw <= sh[0];
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
                LS_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            st <= LS_RBYTE; tx <= rd_byte; sda_oe <= ~rd_byte[7];
                        end else begin
                            st <= LS_WBYTE; sda_oe <= 1'b0;
                        end
                    end
                end
                LS_WBYTE: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (wbyte_ack) begin
                            st <= LS_WACK; sda_oe <= 1'b1;
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
                LS_WACK: begin
                    if (scl_fall) begin
                        st <= LS_WBYTE; sda_oe <= 1'b0; cnt <= '0;
                    end
                end
                LS_RBYTE: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            st <= LS_RACK; sda_oe <= 1'b0;
                        end else begin
                            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
                        end
                    end
                end
                LS_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            st <= LS_RBYTE; tx <= rd_byte; sda_oe <= ~rd_byte[7];
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
                default: st <= LS_IDLE;
            endcase
        end
    end

    // SDA is pulled low only in an acknowledge slot or while sending read data.
    assert_oe_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == LS_AACK || st == LS_WACK || st == LS_RBYTE));
    // A stop always leaves the line released.
    assert_release_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);
    // An address that does not match never reaches an acknowledge slot.
    assert_addr_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != my_addr && !start_ev && !stop_ev)
        |=> (st == LS_IDLE && !sda_oe));
endmodule

// File: rtl/dacif_regs.sv
// Command decoder and register sets. Tracks the byte position within a frame,
// commits complete frames at the final acknowledge and serves the read stream.
// Assumes CODE_W is between 1 and 12.
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              wbyte_valid,
    input  logic [7:0]        wbyte,
    output logic              wbyte_ack,
    input  logic              wack_done,
    input  logic              rd_adv,
    output logic [7:0]        rd_byte,
    input  logic              nv_busy,
    output logic [CODE_W-1:0] dac_code,
    output dac_cfg_t          cfg,
    output logic [CODE_W-1:0] nv_code,
    output dac_cfg_t          nv_cfg,
    output logic              nv_wr
);
    localparam int PAD   = FRAME_CODE_W - CODE_W;
    localparam int NREAD = 6;

    logic [1:0]  widx;
    logic [7:0]  b0, b1, b2;
    logic [1:0]  need_m1;
    logic [2:0]  rd_ptr;
    logic [11:0] code_short, code_long, vol12, nv12;
    dac_cfg_t    cfg_frame;

    // Frame length minus one, selected by the command in the first byte.
    always_comb begin
        case (b0[7:5])
            3'b000, 3'b001: need_m1 = 2'd1;
            3'b010, 3'b011: need_m1 = 2'd2;
            default:        need_m1 = 2'd0;
        endcase
    end

    // Only known commands are acknowledged; later bytes always are.
    assign wbyte_ack  = (widx == 2'd0) ? (wbyte[7:5] <= 3'b100) : 1'b1;
    assign code_short = {b0[3:0], b1};
    assign code_long  = {b1, b2[7:4]};
    assign cfg_frame  = '{ref_sel: b0[4:3], pd: b0[2:1], gain: b0[0]};

    // Capture frame bytes and commit at the acknowledge of the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx <= '0; b0 <= '0; b1 <= '0; b2 <= '0;
            dac_code <= '0; cfg <= '0; nv_code <= '0; nv_cfg <= '0; nv_wr <= 1'b0;
        end else begin
            nv_wr <= 1'b0;
            if (start_ev || stop_ev) begin
                widx <= '0;
            end else begin
                if (wbyte_valid) begin
                    case (widx)
                        2'd0:    b0 <= wbyte;
                        2'd1:    b1 <= wbyte;
                        default: b2 <= wbyte;
                    endcase
                end
                if (wack_done) begin
                    if (widx == need_m1) begin
                        widx <= '0;
                        case (b0[7:5])
                            3'b000, 3'b001: begin
                                dac_code <= code_short[11 -: CODE_W];
                                cfg.pd   <= b0[5:4];
                            end
                            3'b010: begin
                                dac_code <= code_long[11 -: CODE_W];
                                cfg      <= cfg_frame;
                            end
                            3'b011: begin
                                dac_code <= code_long[11 -: CODE_W];
                                cfg      <= cfg_frame;
                                nv_code  <= code_long[11 -: CODE_W];
                                nv_cfg   <= cfg_frame;
                                nv_wr    <= 1'b1;
                            end
                            default: cfg <= cfg_frame;
                        endcase
                    end else begin
                        widx <= widx + 2'd1;
                    end
                end
            end
        end
    end

    // Read pointer: restarts on each start, advances on every master ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (start_ev) begin
            rd_ptr <= '0;
        end else if (rd_adv) begin
            rd_ptr <= (rd_ptr == 3'(NREAD - 1)) ? 3'd0 : rd_ptr + 3'd1;
        end
    end

    assign vol12 = 12'(dac_code) << PAD;
    assign nv12  = 12'(nv_code) << PAD;

    // Read byte selected by the pointer.
    always_comb begin
        case (rd_ptr)
            3'd0:    rd_byte = pack_cfg(~nv_busy, 1'b1, cfg);
            3'd1:    rd_byte = vol12[11:4];
            3'd2:    rd_byte = {vol12[3:0], 4'b0000};
            3'd3:    rd_byte = pack_cfg(~nv_busy, 1'b1, nv_cfg);
            3'd4:    rd_byte = nv12[11:4];
            default: rd_byte = {nv12[3:0], 4'b0000};
        endcase
    end

    // The nonvolatile strobe lasts one cycle.
    assert_nv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr |=> !nv_wr);
    // When the strobe fires, the copy matches the volatile set.
    assert_nv_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr |-> (nv_code == dac_code && nv_cfg == cfg));
    // Registers move only on a frame-ending acknowledge.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wack_done |=> ($stable(dac_code) && $stable(cfg) && $stable(nv_code)));
    // The byte index never passes the longest frame.
    assert_widx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        widx <= 2'd2);
    // The read pointer stays within the six-byte stream.
    assert_rdptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr < 3'(NREAD));
endmodule

// File: rtl/dacif_top.sv
// Two-wire slave front end of a DAC: line synchroniser, link engine and
// command/register decoder. Assumes an open-drain SDA driven via sda_oe_o.
module dacif_top
    import dacif_pkg::*;
#(
    parameter int         CODE_W    = 12,
    parameter int         SYNC_STG  = 2,
    parameter logic [6:0] ADDR_BASE = 7'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_opt_i,
    input  logic              nv_busy_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [1:0]        ref_sel_o,
    output logic              gain_o,
    output logic [1:0]        pd_o,
    output logic [CODE_W-1:0] nv_code_o,
    output logic [1:0]        nv_ref_sel_o,
    output logic              nv_gain_o,
    output logic [1:0]        nv_pd_o,
    output logic              nv_wr_o
);
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wbyte_valid, wbyte_ack, wack_done, rd_adv;
    logic [7:0] wbyte, rd_byte;
    dac_cfg_t   cfg, nv_cfg;

    dacif_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    dacif_link #(.ADDR_BASE(ADDR_BASE)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .addr_opt(addr_opt_i), .sda_oe(sda_oe_o), .wbyte_valid(wbyte_valid),
        .wbyte(wbyte), .wbyte_ack(wbyte_ack), .wack_done(wack_done),
        .rd_adv(rd_adv), .rd_byte(rd_byte)
    );

    dacif_regs #(.CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
        .wbyte_valid(wbyte_valid), .wbyte(wbyte), .wbyte_ack(wbyte_ack),
        .wack_done(wack_done), .rd_adv(rd_adv), .rd_byte(rd_byte),
        .nv_busy(nv_busy_i), .dac_code(dac_code_o), .cfg(cfg),
        .nv_code(nv_code_o), .nv_cfg(nv_cfg), .nv_wr(nv_wr_o)
    );

    assign ref_sel_o    = cfg.ref_sel;
    assign gain_o       = cfg.gain;
    assign pd_o         = cfg.pd;
    assign nv_ref_sel_o = nv_cfg.ref_sel;
    assign nv_gain_o    = nv_cfg.gain;
    assign nv_pd_o      = nv_cfg.pd;
endmodule

// File: tb/tb_dacif_top.sv
module tb_dacif_top;
    localparam int Q = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [1:0] addr_opt = 2'b10;
    logic nv_busy = 1'b0;
    logic [11:0] dac_code, nv_code;
    logic [1:0] ref_sel, pd, nv_ref, nv_pd;
    logic gain, nv_gain, nv_wr;

    int errors = 0, checks = 0, cyc = 0, nv_pulses = 0;
    logic [11:0] m_code = '0, n_code = '0;
    logic [1:0] m_ref = '0, m_pd = '0, n_ref = '0, n_pd = '0;
    logic m_g = 1'b0, n_g = 1'b0;
    logic [7:0] wbuf [0:7];
    logic [7:0] acks;
    logic sampled;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    dacif_top dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_opt_i(addr_opt), .nv_busy_i(nv_busy), .dac_code_o(dac_code),
        .ref_sel_o(ref_sel), .gain_o(gain), .pd_o(pd), .nv_code_o(nv_code),
        .nv_ref_sel_o(nv_ref), .nv_gain_o(nv_gain), .nv_pd_o(nv_pd), .nv_wr_o(nv_wr)
    );

    always @(posedge clk) begin
        if (nv_wr) nv_pulses <= nv_pulses + 1;
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d cycles", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(Q); sampled = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_io(b[i]);
        bit_io(1'b1);
        ack = ~sampled;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1); v[i] = sampled; end
        bit_io(~give_ack);
    endtask

    // Full write transfer: address, then n bytes from wbuf, then stop if asked.
    task automatic write_xfer(input int n, input logic do_stop);
        logic a;
        bus_start();
        send_byte({5'b11000, addr_opt, 1'b0}, a);
        acks = '0;
        acks[7] = a;
        for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); acks[i] = a; end
        if (do_stop) bus_stop();
    endtask

    // Reference model of one complete frame from the requirement layouts.
    task automatic model_frame(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2);
        case (c0[7:5])
            3'b000, 3'b001: begin m_code = {c0[3:0], c1}; m_pd = c0[5:4]; end
            3'b010, 3'b011: begin
                m_code = {c1, c2[7:4]}; m_ref = c0[4:3]; m_pd = c0[2:1]; m_g = c0[0];
                if (c0[5]) begin n_code = m_code; n_ref = m_ref; n_pd = m_pd; n_g = m_g; end
            end
            3'b100: begin m_ref = c0[4:3]; m_pd = c0[2:1]; m_g = c0[0]; end
            default: ;
        endcase
    endtask

    task automatic check_regs(input string req);
        check({req, " code"}, dac_code, m_code);
        check({req, " cfg"}, {ref_sel, pd, gain}, {m_ref, m_pd, m_g});
        check({req, " nv code"}, nv_code, n_code);
        check({req, " nv cfg"}, {nv_ref, nv_pd, nv_gain}, {n_ref, n_pd, n_g});
    endtask

    initial begin
        logic a;
        logic [7:0] v;
        logic held;
        int p0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R11: reset state
        check("R11 sda released", sda_oe, 0);
        check_regs("R11");

        // R1: full address sweep for one option, then matching address for each option
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            bus_stop();
            check("R1 address sweep", a, (ad == 7'h62) ? 1 : 0);
        end
        for (int o = 0; o < 4; o++) begin
            addr_opt = 2'(o);
            for (int ad = 8'h60; ad < 8'h64; ad++) begin
                bus_start();
                send_byte({7'(ad), 1'b0}, a);
                bus_stop();
                check("R1 option match", a, (ad[1:0] == 2'(o)) ? 1 : 0);
            end
        end
        addr_opt = 2'b01;

        // R2: two-byte code/power-down frames over all pd values and both codes 000/001
        for (int k = 0; k < 8; k++) begin
            logic [11:0] c;
            c = 12'((k * 12'h5A3 + 12'h0F1) & 12'hFFF);
            wbuf[0] = {2'b00, 2'(k), c[11:8]};
            wbuf[0][4] = k[2] ^ k[0];
            wbuf[0][5] = k[1];
            wbuf[0][4] = k[0];
            wbuf[0][7:6] = 2'b00;
            wbuf[1] = c[7:0];
            if (k[2]) wbuf[0][5] = ~wbuf[0][5];
            write_xfer(2, 1'b1);
            model_frame(wbuf[0], wbuf[1], 8'h00);
            tick(4);
            check("R2 acks", acks[1:0], 2'b11);
            check_regs("R2");
        end
        // R2: command 001 form
        wbuf[0] = 8'b0011_0101; wbuf[1] = 8'hC3;
        write_xfer(2, 1'b1); model_frame(wbuf[0], wbuf[1], 8'h00); tick(4);
        check_regs("R2 cmd001");

        // R3: volatile full frames, sweep configuration fields
        for (int k = 0; k < 32; k += 5) begin
            wbuf[0] = {3'b010, 5'(k)}; wbuf[1] = 8'(k * 7 + 3); wbuf[2] = {4'(k + 9), 4'hF};
            write_xfer(3, 1'b1); model_frame(wbuf[0], wbuf[1], wbuf[2]); tick(4);
            check_regs("R3");
        end

        // R4: nonvolatile frame with single strobe
        p0 = nv_pulses;
        wbuf[0] = 8'b011_10_11_1; wbuf[1] = 8'hA5; wbuf[2] = 8'h70;
        write_xfer(3, 1'b1); model_frame(wbuf[0], wbuf[1], wbuf[2]); tick(4);
        check_regs("R4");
        check("R4 strobe count", nv_pulses - p0, 1);
        p0 = nv_pulses;
        wbuf[0] = 8'b011_01_00_0; wbuf[1] = 8'h3C; wbuf[2] = 8'h90;
        write_xfer(3, 1'b1); model_frame(wbuf[0], wbuf[1], wbuf[2]); tick(4);
        check_regs("R4 second");
        check("R4 strobe count second", nv_pulses - p0, 1);

        // R5: configuration-only frames, all 32 field values
        for (int k = 0; k < 32; k++) begin
            wbuf[0] = {3'b100, 5'(k)};
            write_xfer(1, 1'b1); model_frame(wbuf[0], 8'h00, 8'h00); tick(4);
            check_regs("R5");
        end

        // R6: truncated frames change nothing (stop, then repeated start)
        wbuf[0] = 8'b010_11_11_1; wbuf[1] = 8'hFF;
        write_xfer(2, 1'b1); tick(4);
        check_regs("R6 truncated by stop");
        wbuf[0] = 8'b0000_1111;
        write_xfer(1, 1'b0);
        wbuf[0] = 8'b100_00_01_0;
        write_xfer(1, 1'b1); model_frame(wbuf[0], 8'h00, 8'h00); tick(4);
        check_regs("R6 truncated by repeated start");

        // R7: unknown commands are refused and ignored
        for (int c = 5; c < 8; c++) begin
            wbuf[0] = {3'(c), 5'b11111}; wbuf[1] = 8'h55;
            write_xfer(2, 1'b1); tick(4);
            check("R7 nack", acks[0], 0);
            check_regs("R7");
        end

        // R8: back-to-back frames of lengths 2, 1 and 3 in one transfer
        wbuf[0] = 8'b0010_1010; wbuf[1] = 8'h11;
        wbuf[2] = 8'b100_10_00_1;
        wbuf[3] = 8'b010_01_10_0; wbuf[4] = 8'hDE; wbuf[5] = 8'hA0;
        write_xfer(6, 1'b1);
        model_frame(wbuf[0], wbuf[1], 8'h00);
        model_frame(wbuf[2], 8'h00, 8'h00);
        model_frame(wbuf[3], wbuf[4], wbuf[5]);
        tick(4);
        check("R8 all acked", acks[5:0], 6'h3F);
        check_regs("R8");

        // R9: read stream with wrap, busy and idle status
        for (int bz = 0; bz < 2; bz++) begin
            nv_busy = 1'(bz);
            bus_start();
            send_byte({5'b11000, addr_opt, 1'b1}, a);
            check("R9 read address ack", a, 1);
            recv_byte(1'b1, v); check("R9 vol status", v, {~bz[0], 1'b1, 1'b0, m_ref, m_pd, m_g});
            recv_byte(1'b1, v); check("R9 vol code hi", v, m_code[11:4]);
            recv_byte(1'b1, v); check("R9 vol code lo", v, {m_code[3:0], 4'h0});
            recv_byte(1'b1, v); check("R9 nv status", v, {~bz[0], 1'b1, 1'b0, n_ref, n_pd, n_g});
            recv_byte(1'b1, v); check("R9 nv code hi", v, n_code[11:4]);
            recv_byte(1'b1, v); check("R9 nv code lo", v, {n_code[3:0], 4'h0});
            recv_byte(1'b0, v); check("R9 wrap", v, {~bz[0], 1'b1, 1'b0, m_ref, m_pd, m_g});
            // R10: after the NACK the slave keeps SDA released
            held = 1'b0;
            for (int i = 0; i < 9; i++) begin
                bit_io(1'b1);
                if (!sampled || sda_oe) held = 1'b1;
            end
            check("R10 released after nack", held, 0);
            bus_stop();
        end
        nv_busy = 1'b0;
        check_regs("R10 state kept");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule